// File: doc/BRIEF.md
# Converter Trigger Aligner with Closed-Loop Phase Calibration

This block sits beside a center-aligned PWM period timer and produces the start request for an analog converter. The request is a rising edge on `trig_out`, placed a programmable number of timer ticks ahead of the period center. The converter does not start on the edge itself. It starts on the next slot of its own arbitration grid, which is `GRID` ticks long. The block therefore records the timer value at the moment the converter reports that it started, and uses that record to steer the real start onto a set point chosen by software.

Each captured start runs one calibration step. The first stage fixes the residue. While the captured start and the set point differ modulo `GRID`, the block asks the period timer for a period one tick shorter. This slides the timer phase past the converter grid one tick per period. The second stage fixes the whole number of grid slots. Once the residues agree, the nominal period is restored and the remaining offset is added to the trigger compare. When a captured start equals the set point, the block stops reacting to conversion starts and raises `cal_done`. Writing a new set point starts calibration again.

The set point enters through a valid/ready port. `setpt_ready` is low while a step is being evaluated. A producer must hold `setpt_valid` and `setpt_data` until it sees ready high at a clock edge, and the value is taken on that edge. The timer count, the wrap strobe and the conversion-start pulse are plain, unbuffered inputs that are sampled every cycle.

Top module: `adc_trig_align`

## Requirements
- R1: On every clock edge where `tmr_wrap` is high, `trig_out` goes low, and that edge also loads the pending trigger compare into the active compare.
- R2: `trig_out` goes high on the clock edge where `tmr_wrap` is low and `tmr_cnt` equals the active compare, so there is exactly one rising edge per period.
- R3: After reset, `trig_out` is 0, `period_adj` is `NOM_PERIOD`, `cal_done` is 1 and `setpt_ready` is 1. Both the active and the pending compare are `NOM_PERIOD/2 - PRETRIG_SLOTS*GRID`, which is 19 for a nominal period of 398 with 9 slots of 20.
- R4: `conv_start` is ignored in three cases: while `cal_done` is 1, while a step is being evaluated, and on the edge that accepts a set point. An ignored pulse changes neither `period_adj` nor the compare nor `cal_done`.
- R5: If the set point modulo `GRID` differs from the captured count modulo `GRID`, `period_adj` becomes `NOM_PERIOD-1` within `CNT_W+3` cycles of the capture edge. It takes effect immediately and holds until a later step finds equal residues.
- R6: If the residues are equal, `period_adj` returns to `NOM_PERIOD`. If the captured count also equals the set point, `cal_done` rises and later conversion starts are ignored.
- R7: If the residues are equal but the values differ, the pending compare becomes the pending compare plus (set point minus capture), modulo 2^`CNT_W`. The trigger edge moves only after the next wrap.
- R8: `setpt_ready` is high exactly when no step is in evaluation. An accepted set point (valid and ready at an edge) is stored and drives `cal_done` low on that edge.
- R9: If the converter starts on a fixed grid of `GRID` ticks and the nominal period plus two is a multiple of `GRID`, calibration ends within `GRID+2` steps, and the last captured start equals the set point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the period timer |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_cnt | input | CNT_W | Current period timer count (all ones right after a wrap) |
| tmr_wrap | input | 1 | High in the cycle the timer holds its wrap value |
| conv_start | input | 1 | One-cycle pulse from the converter at start of conversion |
| setpt_data | input | CNT_W | Requested timer count for the converter start |
| setpt_valid | input | 1 | Set point offered |
| setpt_ready | output | 1 | Set point can be taken at this edge |
| trig_out | output | 1 | Converter start request; the rising edge is the request |
| period_adj | output | CNT_W | Period compare value for the timer, nominal or nominal minus one |
| cal_done | output | 1 | Calibration finished; capture of conversion starts disabled |

## Verification
The bench models the timer and a converter that starts on a free-running grid. It sweeps set points that cover three cases: an exact hit, a pure whole-slot offset and residue mismatches. For each captured start it predicts the step's outcome from the two residues. A design that swapped the branches, or applied the period change one period late, would never settle: every step would overshoot the grid phase by one tick. The bench also predicts where each trigger edge should fall. A compare update that bypassed the wrap shadow would show up as a misplaced edge in the period where the step ran. Conversion starts that arrive after completion must leave the period and the done flag untouched; a design that kept capturing would keep moving the period.

// File: rtl/ata_pkg.sv
package ata_pkg;

  typedef enum logic [0:0] {
    CAL_IDLE = 1'b0,
    CAL_EVAL = 1'b1
  } cal_state_e;

  function automatic int ata_init_cmp(input int nom, input int slots, input int grid);
    return nom / 2 - slots * grid;
  endfunction

endpackage

// File: rtl/ata_mod_unit.sv
// Bit-serial restoring remainder: one dividend bit per cycle.
module ata_mod_unit #(
  parameter int W = 16,
  parameter int M = 20,
  localparam int RW = $clog2(M) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  din,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] rem
);
  localparam int IW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [RW-1:0] rem_q, trial, rem_nx;
  logic [IW-1:0] idx_q;
  logic          busy_q, done_q;

  always_comb begin
    trial  = {rem_q[RW-2:0], sh_q[W-1]};
    rem_nx = (trial >= RW'(M)) ? trial - RW'(M) : trial;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rem_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        sh_q   <= din;
        rem_q  <= '0;
        idx_q  <= IW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_nx;
        sh_q  <= {sh_q[W-2:0], 1'b0};
        idx_q <= idx_q - 1'b1;
        if (idx_q == IW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign rem  = rem_q;
endmodule

// File: rtl/ata_trig_gen.sv
// Trigger edge generator with a compare shadowed to the period wrap.
module ata_trig_gen #(
  parameter int W        = 16,
  parameter int INIT_CMP = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr_cnt,
  input  logic         tmr_wrap,
  input  logic [W-1:0] cmp_pend,
  output logic         trig,
  output logic [W-1:0] cmp_act
);
  logic         trig_q;
  logic [W-1:0] cmp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      cmp_q  <= W'(INIT_CMP);
    end else if (tmr_wrap) begin
      trig_q <= 1'b0;
      cmp_q  <= cmp_pend;
    end else if (tmr_cnt == cmp_q) begin
      trig_q <= 1'b1;
    end
  end

  assign trig    = trig_q;
  assign cmp_act = cmp_q;
endmodule

// File: rtl/ata_cal_ctrl.sv
// One calibration step per captured conversion start.
module ata_cal_ctrl
  import ata_pkg::*;
#(
  parameter int W        = 16,
  parameter int GRID     = 20,
  parameter int NOM      = 398,
  parameter int INIT_CMP = 19,
  localparam int RW      = $clog2(GRID) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  tmr_cnt,
  input  logic          conv_start,
  input  logic [W-1:0]  setpt_data,
  input  logic          setpt_valid,
  output logic          setpt_ready,
  input  logic [RW-1:0] rem_sp,
  input  logic [RW-1:0] rem_cap,
  input  logic          mod_done,
  output logic          mod_start,
  output logic [W-1:0]  sp_val,
  output logic [W-1:0]  cmp_pend,
  output logic [W-1:0]  period_adj,
  output logic          cal_en
);
  cal_state_e   st_q;
  logic [W-1:0] sp_q, cap_q, cmp_q, per_q;
  logic         en_q;
  logic         take_sp;

  assign setpt_ready = (st_q == CAL_IDLE);
  assign take_sp     = setpt_valid && setpt_ready;
  assign mod_start   = (st_q == CAL_IDLE) && !setpt_valid && conv_start && en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= CAL_IDLE;
      sp_q  <= '0;
      cap_q <= '0;
      cmp_q <= W'(INIT_CMP);
      per_q <= W'(NOM);
      en_q  <= 1'b0;
    end else begin
      unique case (st_q)
        CAL_IDLE: begin
          if (take_sp) begin
            sp_q <= setpt_data;
            en_q <= 1'b1;
          end else if (mod_start) begin
            cap_q <= tmr_cnt;
            st_q  <= CAL_EVAL;
          end
        end
        CAL_EVAL: begin
          if (mod_done) begin
            st_q <= CAL_IDLE;
            if (rem_sp != rem_cap) begin
              per_q <= W'(NOM - 1);
            end else begin
              per_q <= W'(NOM);
              if (sp_q == cap_q) en_q  <= 1'b0;
              else               cmp_q <= cmp_q + (sp_q - cap_q);
            end
          end
        end
        default: st_q <= CAL_IDLE;
      endcase
    end
  end

  assign sp_val     = sp_q;
  assign cmp_pend   = cmp_q;
  assign period_adj = per_q;
  assign cal_en     = en_q;
endmodule

// File: rtl/adc_trig_align.sv
module adc_trig_align
  import ata_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int GRID          = 20,
  parameter int NOM_PERIOD    = 398,
  parameter int PRETRIG_SLOTS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tmr_cnt,
  input  logic             tmr_wrap,
  input  logic             conv_start,
  input  logic [CNT_W-1:0] setpt_data,
  input  logic             setpt_valid,
  output logic             setpt_ready,
  output logic             trig_out,
  output logic [CNT_W-1:0] period_adj,
  output logic             cal_done
);
  localparam int INIT_CMP = ata_init_cmp(NOM_PERIOD, PRETRIG_SLOTS, GRID);
  localparam int REM_W    = $clog2(GRID) + 1;
  localparam int N_OPS    = 2;  // operand 0: set point, operand 1: capture

  logic [CNT_W-1:0] cmp_pend, cmp_act, sp_val;
  logic             mod_start, cal_en;
  logic [CNT_W-1:0] op_din [N_OPS];
  logic [REM_W-1:0] op_rem [N_OPS];
  logic [N_OPS-1:0] op_busy, op_done;
  logic             mod_busy, mod_done;

  assign op_din[0] = sp_val;
  assign op_din[1] = tmr_cnt;
  assign mod_busy  = |op_busy;
  assign mod_done  = &op_done;

  for (genvar g = 0; g < N_OPS; g++) begin : g_mod
    ata_mod_unit #(.W(CNT_W), .M(GRID)) u_mod (
      .clk   (clk),
      .rst_n (rst_n),
      .start (mod_start),
      .din   (op_din[g]),
      .busy  (op_busy[g]),
      .done  (op_done[g]),
      .rem   (op_rem[g])
    );
  end

  ata_cal_ctrl #(
    .W(CNT_W), .GRID(GRID), .NOM(NOM_PERIOD), .INIT_CMP(INIT_CMP)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_cnt     (tmr_cnt),
    .conv_start  (conv_start),
    .setpt_data  (setpt_data),
    .setpt_valid (setpt_valid),
    .setpt_ready (setpt_ready),
    .rem_sp      (op_rem[0]),
    .rem_cap     (op_rem[1]),
    .mod_done    (mod_done),
    .mod_start   (mod_start),
    .sp_val      (sp_val),
    .cmp_pend    (cmp_pend),
    .period_adj  (period_adj),
    .cal_en      (cal_en)
  );

  ata_trig_gen #(.W(CNT_W), .INIT_CMP(INIT_CMP)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_cnt  (tmr_cnt),
    .tmr_wrap (tmr_wrap),
    .cmp_pend (cmp_pend),
    .trig     (trig_out),
    .cmp_act  (cmp_act)
  );

  assign cal_done = !cal_en;
endmodule

// File: rtl/ata_checker.sv
module ata_checker #(
  parameter int W   = 16,
  parameter int NOM = 398
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tmr_wrap,
  input logic [W-1:0] tmr_cnt,
  input logic         trig_out,
  input logic [W-1:0] cmp_act,
  input logic [W-1:0] period_adj,
  input logic         cal_done,
  input logic         setpt_valid,
  input logic         setpt_ready,
  input logic         mod_busy
);
  a_r1_wrap_clears_trig: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> !trig_out);

  a_r2_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> ($past(tmr_cnt) == $past(cmp_act)));

  a_r7_cmp_moves_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wrap |=> $stable(cmp_act));

  a_r5_period_two_values: assert property (@(posedge clk) disable iff (!rst_n)
    (period_adj == W'(NOM)) || (period_adj == W'(NOM - 1)));

  a_r6_done_nominal: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (period_adj == W'(NOM)));

  a_r4_done_freezes_period: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !(setpt_valid && setpt_ready)) |=> ($stable(period_adj) && cal_done));

  a_r8_accept_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    (setpt_valid && setpt_ready) |=> !cal_done);

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mod_busy |-> !setpt_ready);
endmodule

bind adc_trig_align ata_checker #(.W(CNT_W), .NOM(NOM_PERIOD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tmr_wrap    (tmr_wrap),
  .tmr_cnt     (tmr_cnt),
  .trig_out    (trig_out),
  .cmp_act     (cmp_act),
  .period_adj  (period_adj),
  .cal_done    (cal_done),
  .setpt_valid (setpt_valid),
  .setpt_ready (setpt_ready),
  .mod_busy    (mod_busy)
);

// File: tb/adc_trig_align_tb.sv
module adc_trig_align_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int GRID       = 20;
  localparam int NOM        = 398;
  localparam int PRE        = 9;
  localparam int EXP_INIT   = NOM / 2 - PRE * GRID;
  localparam int LAT        = 3;
  localparam int DEC_DLY    = W + 8;
  localparam int TMO        = 40 * (NOM + 2);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tmr_cnt = '1;
  logic         tmr_wrap = 1'b1;
  logic         conv_start = 1'b0;
  logic [W-1:0] setpt_data = '0;
  logic         setpt_valid = 1'b0;
  logic         setpt_ready, trig_out, cal_done;
  logic [W-1:0] period_adj;

  int checks = 0, errors = 0;
  // bench models
  bit run_model = 0, pend = 0, cal_active = 0, sending = 0, ready_chk = 0;
  bit trig_prev = 0, exp_done = 0;
  int arb = 0, lat = 0, last_cap = -1, sp_bench = 0, dec_cnt = 0;
  int exp_act = EXP_INIT, exp_nxt = EXP_INIT, exp_per = NOM, steps = 0;
  string exp_tag = "R5";

  adc_trig_align #(.CNT_W(W), .GRID(GRID), .NOM_PERIOD(NOM), .PRETRIG_SLOTS(PRE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .tmr_wrap(tmr_wrap),
    .conv_start(conv_start), .setpt_data(setpt_data), .setpt_valid(setpt_valid),
    .setpt_ready(setpt_ready), .trig_out(trig_out), .period_adj(period_adj),
    .cal_done(cal_done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // timer, converter grid and per-step predictions, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (run_model) begin
        if (tmr_cnt == '1) begin
          exp_act = exp_nxt;
          check(trig_out == 1'b0, "R1", int'(trig_out), 0);
        end else if (trig_out && !trig_prev) begin
          check(int'(tmr_cnt) == exp_act, "R2 rise position", int'(tmr_cnt), exp_act);
          pend = 1;
          lat  = LAT;
        end
        trig_prev = trig_out;
        if (ready_chk) begin
          ready_chk = 0;
          check(setpt_ready == 1'b0, "R8 ready low in step", int'(setpt_ready), 0);
        end
        if (dec_cnt > 0) begin
          dec_cnt--;
          if (dec_cnt == 0) begin
            check(int'(period_adj) == exp_per, exp_tag, int'(period_adj), exp_per);
            check(cal_done == exp_done, "R6 done", int'(cal_done), int'(exp_done));
          end
        end
        if (tmr_cnt == period_adj) tmr_cnt = '1;
        else                       tmr_cnt = tmr_cnt + 1'b1;
        tmr_wrap   = (tmr_cnt == '1);
        arb        = (arb + 1) % GRID;
        conv_start = 1'b0;
        if (pend) begin
          if (lat > 0) lat--;
          else if (arb == 0) begin
            conv_start = 1'b1;
            pend       = 0;
            last_cap   = int'(tmr_cnt);
            if (cal_active && !sending && dec_cnt == 0) begin
              steps++;
              if ((sp_bench % GRID) != (last_cap % GRID)) begin
                exp_per = NOM - 1; exp_done = 0; exp_tag = "R5 residue mismatch";
              end else begin
                exp_per = NOM;
                if (sp_bench == last_cap) begin
                  exp_done = 1; cal_active = 0; exp_tag = "R6 exact hit";
                end else begin
                  exp_done = 0; exp_tag = "R7 slot offset";
                  exp_nxt = (exp_nxt + sp_bench - last_cap) & 16'hFFFF;
                end
              end
              dec_cnt   = DEC_DLY;
              ready_chk = 1;
            end
          end
        end
      end
    end
  end

  task automatic send_sp(input int sp);
    do begin @(posedge clk); #2; end while (!setpt_ready);
    sending     = 1;
    sp_bench    = sp;
    setpt_data  = W'(sp);
    setpt_valid = 1'b1;
    @(posedge clk); #2;
    setpt_valid = 1'b0;
    sending     = 0;
    cal_active  = 1;
    steps       = 0;
    check(cal_done == 1'b0, "R8 accept clears done", int'(cal_done), 0);
  endtask

  task automatic run_cal(input int sp, input int max_steps);
    int waited;
    send_sp(sp);
    waited = 0;
    while ((cal_active || dec_cnt != 0) && waited < TMO) begin
      @(negedge clk);
      waited++;
    end
    check(cal_done == 1'b1, "R9 finished", int'(cal_done), 1);
    check(last_cap == sp, "R9 start on set point", last_cap, sp);
    check(steps <= max_steps, "R9 step bound", steps, max_steps);
    repeat (2 * (NOM + 2)) @(negedge clk);
    check(int'(period_adj) == NOM, "R4 ignored after done", int'(period_adj), NOM);
    check(cal_done == 1'b1 && setpt_ready == 1'b1, "R4 done held", int'(cal_done), 1);
    check(last_cap == sp, "R4 start stays aligned", last_cap, sp);
  endtask

  initial begin
    int base;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(trig_out == 1'b0, "R3 trig", int'(trig_out), 0);
    check(int'(period_adj) == NOM, "R3 period", int'(period_adj), NOM);
    check(cal_done == 1'b1, "R3 done", int'(cal_done), 1);
    check(setpt_ready == 1'b1, "R3 ready", int'(setpt_ready), 1);
    run_model = 1;
    repeat (3 * (NOM + 2)) @(negedge clk);
    check(int'(period_adj) == NOM, "R4 ignored before set point", int'(period_adj), NOM);
    check(cal_done == 1'b1, "R4 done before set point", int'(cal_done), 1);
    base = last_cap;
    run_cal(base, 1);          // R6: one step, exact hit
    run_cal(base + 40, 2);     // R7: whole-slot offset only
    begin
      int sps[5] = '{123, 257, 201, 88, 160};
      foreach (sps[i]) run_cal(sps[i], GRID + 2);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog expired: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule